// File: doc/BRIEF.md
# Iterative AES-128 Round Datapath

This block runs AES-128 one round per clock on a single round's worth of logic. The same substitution, row-rotation and column-mixing hardware serves both encryption and decryption, and the mode bit selects the direction through multiplexers. A block is captured on a start strobe. The block then consumes eleven round keys, one per cycle: an initial key addition, nine full rounds, and a last round with no column mixing. It returns the result with a one-cycle done pulse.

Round keys come from an external key scheduler, one 128-bit key per cycle. The datapath tells the scheduler which key it needs through a round-key index output. A key-valid input holds the datapath still for as long as it stays low. Each block is processed on its own, with no chaining between blocks.

The state is held column-major: byte k of the 128-bit bus sits at bits [127-8k -: 8] and belongs to column k/4, row k%4. For decryption the round keys arrive in reverse order. Each round then applies inverse rotation, inverse substitution, key addition and inverse mixing, in that order.

Top module: `aes_iter_core`

## Requirements
- R1: After reset, busy_o=0, done_o=0, key_round_o=0 and block_o=0. A start_i sampled while idle captures block_i and decrypt_i (1 = decrypt, 0 = encrypt), and busy_o is 1 in the next cycle.
- R2: A start_i sampled while busy_o=1 is ignored, together with the decrypt_i and block_i that come with it. The key index sequence and the result are the same as they would be without it.
- R3: Encryption of the FIPS-197 AES-128 vectors gives the standard ciphertext. Each round uses the order substitute, rotate rows left by the row number, mix columns, add key. The last round leaves out the mixing.
- R4: Decryption of the standard ciphertexts returns the plaintext. Each round uses the order rotate rows right by the row number, inverse substitute, add key, inverse mix. The last round leaves out the inverse mixing.
- R5: When rkey_valid_i stays high, done_o rises exactly 11 clock edges after the edge that accepted start_i. This is one key-consuming edge for the initial key addition and one for each of the 10 rounds.
- R6: While rkey_valid_i=0, the state and key_round_o hold and rkey_i has no effect. Each stalled cycle adds exactly one cycle to the latency.
- R7: done_o is high for exactly one cycle. block_o holds the result from then until the next accepted start.
- R8: While busy, key_round_o gives the index of the round key needed in this cycle. When encrypting it is the step count 0..10; when decrypting it is 10 minus the step count, i.e. 10..0. When idle it is 0.
- R9: Encryption followed by decryption of random blocks under random keys returns the original block. This holds with and without stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin processing block_i when idle |
| decrypt_i | input | 1 | Direction for the block being started: 1 decrypt, 0 encrypt |
| block_i | input | 128 | Input block, byte 0 in bits 127:120 |
| rkey_i | input | 128 | Round key for the current step, same byte layout |
| rkey_valid_i | input | 1 | rkey_i is valid; low stalls the datapath |
| key_round_o | output | 4 | Index of the round key needed now |
| busy_o | output | 1 | A block is in progress |
| done_o | output | 1 | One-cycle pulse when block_o holds a new result |
| block_o | output | 128 | Result block |

## Verification
The bench builds the block with its default of 10 rounds, which puts the two published AES-128 vectors within reach in both directions. It feeds round keys that it expands itself, indexed by key_round_o. Random stall patterns let it check the extra latency and that keys are ignored while stalled. Some runs inject a conflicting start mid-block. Random round trips exercise every substitution-table entry through both the forward and the inverse affine maps.

// File: rtl/aes_iter_pkg.sv
package aes_iter_pkg;
  localparam int ROWS   = 4;
  localparam int COLS   = 4;
  localparam int NBYTES = ROWS * COLS;
  localparam int BLK_W  = 8 * NBYTES;

  typedef logic [7:0] byte_t;

  function automatic byte_t gf_xtime(byte_t a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic byte_t gf_mul(byte_t a, byte_t b);
    byte_t acc = 8'h00;
    byte_t p   = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ p;
      p = gf_xtime(p);
    end
    return acc;
  endfunction

  // a^254 equals the multiplicative inverse; zero maps to zero
  function automatic byte_t gf_inverse(byte_t a);
    byte_t r = 8'h01;
    byte_t p = a;
    for (int i = 0; i < 8; i++) begin
      if (i != 0) r = gf_mul(r, p);
      p = gf_mul(p, p);
    end
    return r;
  endfunction

  function automatic byte_t rotl8(byte_t x, int k);
    return byte_t'((x << k) | (x >> (8 - k)));
  endfunction

  function automatic byte_t affine_fwd(byte_t b);
    return b ^ rotl8(b, 1) ^ rotl8(b, 2) ^ rotl8(b, 3) ^ rotl8(b, 4) ^ 8'h63;
  endfunction

  function automatic byte_t affine_inv(byte_t s);
    return rotl8(s, 1) ^ rotl8(s, 3) ^ rotl8(s, 6) ^ 8'h05;
  endfunction

  // col = {row0,row1,row2,row3}; inverse mixing = pre-conditioning + forward mixing
  function automatic logic [31:0] mix_column(logic [31:0] col, logic inv);
    byte_t a0, a1, a2, a3, u, v, t;
    a0 = col[31:24]; a1 = col[23:16]; a2 = col[15:8]; a3 = col[7:0];
    if (inv) begin
      u  = gf_xtime(gf_xtime(a0 ^ a2));
      v  = gf_xtime(gf_xtime(a1 ^ a3));
      a0 = a0 ^ u; a2 = a2 ^ u;
      a1 = a1 ^ v; a3 = a3 ^ v;
    end
    t = a0 ^ a1 ^ a2 ^ a3;
    return {a0 ^ t ^ gf_xtime(a0 ^ a1),
            a1 ^ t ^ gf_xtime(a1 ^ a2),
            a2 ^ t ^ gf_xtime(a2 ^ a3),
            a3 ^ t ^ gf_xtime(a3 ^ a0)};
  endfunction
endpackage

// File: rtl/aes_sub_bank.sv
module aes_sub_bank
  import aes_iter_pkg::*;
#(
  parameter int NB = NBYTES
) (
  input  logic [8*NB-1:0] din,
  input  logic            inv,
  output logic [8*NB-1:0] dout
);
  // one shared inverse table, one read port per byte lane
  byte_t inv_tbl [256];

  for (genvar e = 0; e < 256; e++) begin : g_tbl
    assign inv_tbl[e] = gf_inverse(byte_t'(e));
  end

  for (genvar j = 0; j < NB; j++) begin : g_lane
    byte_t lane_in, lane_pre, lane_inv;
    assign lane_in  = din[8*(NB-1-j) +: 8];
    assign lane_pre = inv ? affine_inv(lane_in) : lane_in;
    assign lane_inv = inv_tbl[lane_pre];
    assign dout[8*(NB-1-j) +: 8] = inv ? lane_inv : affine_fwd(lane_inv);
  end
endmodule

// File: rtl/aes_row_shift.sv
module aes_row_shift
  import aes_iter_pkg::*;
#(
  parameter int NR_ROWS = ROWS,
  parameter int NR_COLS = COLS,
  localparam int NB = NR_ROWS * NR_COLS
) (
  input  logic [8*NB-1:0] din,
  input  logic            inv,
  output logic [8*NB-1:0] dout
);
  for (genvar c = 0; c < NR_COLS; c++) begin : g_col
    for (genvar r = 0; r < NR_ROWS; r++) begin : g_row
      localparam int DST = NR_ROWS * c + r;
      localparam int SRC_L = NR_ROWS * ((c + r) % NR_COLS) + r;
      localparam int SRC_R = NR_ROWS * ((c + NR_COLS - (r % NR_COLS)) % NR_COLS) + r;
      assign dout[8*(NB-1-DST) +: 8] = inv ? din[8*(NB-1-SRC_R) +: 8]
                                           : din[8*(NB-1-SRC_L) +: 8];
    end
  end
endmodule

// File: rtl/aes_mix_key.sv
module aes_mix_key
  import aes_iter_pkg::*;
#(
  parameter int NR_COLS = COLS,
  localparam int W = 32 * NR_COLS
) (
  input  logic [W-1:0] din,
  input  logic [W-1:0] rkey,
  input  logic         inv,
  input  logic         skip_mix,
  output logic [W-1:0] dout
);
  logic [W-1:0] pre, mixed;

  // decrypt adds the key before mixing, encrypt after
  assign pre = inv ? (din ^ rkey) : din;

  for (genvar c = 0; c < NR_COLS; c++) begin : g_col
    assign mixed[W-1-32*c -: 32] = skip_mix ? pre[W-1-32*c -: 32]
                                            : mix_column(pre[W-1-32*c -: 32], inv);
  end

  assign dout = inv ? mixed : (mixed ^ rkey);
endmodule

// File: rtl/aes_round_ctl.sv
module aes_round_ctl #(
  parameter int NUM_ROUNDS = 10,
  localparam int STEP_W = $clog2(NUM_ROUNDS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              decrypt_i,
  input  logic              key_valid_i,
  output logic              busy_o,
  output logic              dec_o,
  output logic              accept_o,
  output logic              advance_o,
  output logic              first_o,
  output logic              final_o,
  output logic              done_o,
  output logic [STEP_W-1:0] key_round_o
);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(NUM_ROUNDS);

  logic              busy_q, dec_q, done_q;
  logic [STEP_W-1:0] step_q;

  assign accept_o  = start_i && !busy_q;
  assign advance_o = busy_q && key_valid_i;
  assign first_o   = step_q == '0;
  assign final_o   = step_q == LAST;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      dec_q  <= 1'b0;
      done_q <= 1'b0;
      step_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept_o) begin
        busy_q <= 1'b1;
        dec_q  <= decrypt_i;
        step_q <= '0;
      end else if (advance_o) begin
        if (final_o) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          step_q <= '0;
        end else begin
          step_q <= step_q + 1'b1;
        end
      end
    end
  end

  assign busy_o      = busy_q;
  assign dec_o       = dec_q;
  assign done_o      = done_q;
  assign key_round_o = !busy_q ? '0 : (dec_q ? LAST - step_q : step_q);

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !key_valid_i) |=> ($stable(step_q) && busy_q));

  p_ignore_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start_i) |=> $stable(dec_q));

  p_step_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    step_q <= LAST);

  p_finish_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && key_valid_i && step_q == LAST) |=> (done_q && !busy_q));

  p_idle_index_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> key_round_o == '0);
endmodule

// File: rtl/aes_iter_core.sv
module aes_iter_core
  import aes_iter_pkg::*;
#(
  parameter int NUM_ROUNDS = 10,
  localparam int STEP_W = $clog2(NUM_ROUNDS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              decrypt_i,
  input  logic [BLK_W-1:0]  block_i,
  input  logic [BLK_W-1:0]  rkey_i,
  input  logic              rkey_valid_i,
  output logic [STEP_W-1:0] key_round_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [BLK_W-1:0]  block_o
);
  logic             dec, accept, advance, first_step, final_step;
  logic [BLK_W-1:0] state_q, shifted, subbed, round_out;

  aes_round_ctl #(.NUM_ROUNDS(NUM_ROUNDS)) u_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .decrypt_i   (decrypt_i),
    .key_valid_i (rkey_valid_i),
    .busy_o      (busy_o),
    .dec_o       (dec),
    .accept_o    (accept),
    .advance_o   (advance),
    .first_o     (first_step),
    .final_o     (final_step),
    .done_o      (done_o),
    .key_round_o (key_round_o)
  );

  // rotation and substitution commute bytewise, so one order serves both modes
  aes_row_shift u_shift (.din(state_q), .inv(dec), .dout(shifted));
  aes_sub_bank  u_sub   (.din(shifted), .inv(dec), .dout(subbed));
  aes_mix_key   u_mix   (.din(subbed), .rkey(rkey_i), .inv(dec),
                         .skip_mix(final_step), .dout(round_out));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= '0;
    end else if (accept) begin
      state_q <= block_i;
    end else if (advance) begin
      state_q <= first_step ? (state_q ^ rkey_i) : round_out;
    end
  end

  assign block_o = state_q;

  p_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (state_q == $past(block_i) && busy_o));

  p_out_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> $stable(state_q));

  p_stall_state_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !rkey_valid_i) |=> $stable(state_q));
endmodule

// File: tb/aes_iter_core_test.sv
module aes_iter_core_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0;
  logic         decrypt_i = 1'b0;
  logic [127:0] block_i = '0;
  logic [127:0] rkey_i = '0;
  logic         rkey_valid_i = 1'b0;
  logic [3:0]   key_round_o;
  logic         busy_o, done_o;
  logic [127:0] block_o;

  int checks = 0;
  int failures = 0;

  int lg [256];
  int alg [256];
  logic [7:0] sb [256];
  logic [7:0] isb [256];
  logic [127:0] rk [11];

  always #2 clk = ~clk;

  aes_iter_core uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .decrypt_i(decrypt_i),
    .block_i(block_i), .rkey_i(rkey_i), .rkey_valid_i(rkey_valid_i),
    .key_round_o(key_round_o), .busy_o(busy_o), .done_o(done_o), .block_o(block_o)
  );

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  // ---- reference model built on log/antilog tables ----
  function automatic logic [7:0] gm(logic [7:0] a, logic [7:0] b);
    if (a == 0 || b == 0) return 8'h00;
    return 8'(alg[(lg[a] + lg[b]) % 255]);
  endfunction

  task automatic build_tables();
    int x = 1;
    for (int i = 0; i < 255; i++) begin
      alg[i] = x;
      lg[x] = i;
      x = x ^ ((x << 1) ^ (((x >> 7) & 1) != 0 ? 9'h11b : 9'h000));
      x = x & 8'hff;
    end
    for (int v = 0; v < 256; v++) begin
      logic [7:0] b, s;
      b = (v == 0) ? 8'h00 : 8'(alg[(255 - lg[v]) % 255]);
      for (int i = 0; i < 8; i++)
        s[i] = b[i] ^ b[(i+4)%8] ^ b[(i+5)%8] ^ b[(i+6)%8] ^ b[(i+7)%8] ^ ((8'h63 >> i) & 1);
      sb[v] = s;
      isb[s] = 8'(v);
    end
  endtask

  function automatic logic [7:0] gb(logic [127:0] v, int i);
    return v[127-8*i -: 8];
  endfunction

  function automatic logic [127:0] m_sub(logic [127:0] v, bit inv);
    logic [127:0] o;
    for (int i = 0; i < 16; i++) o[127-8*i -: 8] = inv ? isb[gb(v, i)] : sb[gb(v, i)];
    return o;
  endfunction

  function automatic logic [127:0] m_shift(logic [127:0] v, bit inv);
    logic [127:0] o;
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++)
        o[127-8*(4*c+r) -: 8] = gb(v, 4*(inv ? (c - r + 4) % 4 : (c + r) % 4) + r);
    return o;
  endfunction

  function automatic logic [127:0] m_mix(logic [127:0] v, bit inv);
    logic [127:0] o;
    logic [7:0] cf [4];
    logic [7:0] acc;
    if (inv) begin cf[0]=8'd14; cf[1]=8'd11; cf[2]=8'd13; cf[3]=8'd9; end
    else     begin cf[0]=8'd2;  cf[1]=8'd3;  cf[2]=8'd1;  cf[3]=8'd1; end
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++) begin
        acc = 8'h00;
        for (int k = 0; k < 4; k++) acc = acc ^ gm(cf[(k - r + 4) % 4], gb(v, 4*c+k));
        o[127-8*(4*c+r) -: 8] = acc;
      end
    return o;
  endfunction

  task automatic expand(input logic [127:0] key);
    logic [31:0] w [44];
    logic [31:0] t;
    logic [7:0] rc = 8'h01;
    for (int i = 0; i < 4; i++) w[i] = key[127-32*i -: 32];
    for (int i = 4; i < 44; i++) begin
      t = w[i-1];
      if (i % 4 == 0) begin
        t = {t[23:0], t[31:24]};
        t = {sb[t[31:24]], sb[t[23:16]], sb[t[15:8]], sb[t[7:0]]} ^ {rc, 24'h0};
        rc = gm(rc, 8'h02);
      end
      w[i] = w[i-4] ^ t;
    end
    for (int r = 0; r < 11; r++) rk[r] = {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]};
  endtask

  function automatic logic [127:0] m_enc(logic [127:0] pt);
    logic [127:0] s = pt ^ rk[0];
    for (int r = 1; r <= 10; r++) begin
      s = m_shift(m_sub(s, 0), 0);
      if (r < 10) s = m_mix(s, 0);
      s = s ^ rk[r];
    end
    return s;
  endfunction

  function automatic logic [127:0] m_dec(logic [127:0] ct);
    logic [127:0] s = ct ^ rk[10];
    for (int r = 9; r >= 0; r--) begin
      s = m_sub(m_shift(s, 1), 1) ^ rk[r];
      if (r > 0) s = m_mix(s, 1);
    end
    return s;
  endfunction

  // ---- drive one block through the DUT acting as key scheduler ----
  task automatic run_block(input logic [127:0] din, input bit dec, input bit stall, input bit poke,
                           output logic [127:0] dout, output int cyc, output int stalls,
                           output bit kr_ok, output bit busy_ok);
    int step;
    bit v;
    @(negedge clk);
    start_i = 1'b1; decrypt_i = dec; block_i = din;
    @(negedge clk);
    start_i = 1'b0; block_i = rnd128();
    step = 0; cyc = 0; stalls = 0; kr_ok = 1'b1; busy_ok = busy_o;
    while (!done_o && cyc < 100) begin
      if (key_round_o != (dec ? 4'(10 - step) : 4'(step))) kr_ok = 1'b0;
      if (!busy_o) busy_ok = 1'b0;
      v = stall ? ($urandom_range(2) != 0) : 1'b1;
      rkey_valid_i = v;
      rkey_i = v ? rk[key_round_o] : rnd128();
      start_i = poke && (step == 4);
      decrypt_i = !dec;
      block_i = rnd128();
      @(negedge clk);
      cyc++;
      if (v) step++; else stalls++;
    end
    start_i = 1'b0; rkey_valid_i = 1'b0; rkey_i = rnd128();
    dout = block_o;
  endtask

  task automatic full_check(input logic [127:0] key, input logic [127:0] din, input bit dec,
                            input bit stall, input bit poke, input logic [127:0] exp,
                            input string tag, output logic [127:0] got);
    int cyc, stalls;
    bit kr_ok, busy_ok;
    expand(key);
    run_block(din, dec, stall, poke, got, cyc, stalls, kr_ok, busy_ok);
    chk(got === exp, tag, got, exp);
    chk(kr_ok, "R8 key index sequence", 128'(key_round_o), 128'(kr_ok));
    chk(busy_ok, "R1 busy after accepted start", 128'(busy_o), 128'd1);
    if (poke) chk(kr_ok && got === exp, "R2 start while busy ignored", got, exp);
    if (stall) chk(cyc == 11 + stalls, "R6 stall adds latency", 128'(cyc), 128'(11 + stalls));
    else       chk(cyc == 11, "R5 latency 11 edges", 128'(cyc), 128'd11);
    @(negedge clk);
    chk(!done_o, "R7 done one cycle", 128'(done_o), 128'd0);
    for (int i = 0; i < 3; i++) begin
      block_i = rnd128(); decrypt_i = ~decrypt_i;
      @(negedge clk);
    end
    chk(block_o === got, "R7 output held until next start", block_o, got);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    logic [127:0] got, k, p, c;
    void'($urandom(32'd20240611));
    build_tables();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_o && !done_o && key_round_o == 0 && block_o == 0, "R1 reset state",
        {busy_o, done_o, key_round_o, block_o[121:0]}, 128'd0);

    // R3 / R4 published vectors
    full_check(128'h000102030405060708090a0b0c0d0e0f, 128'h00112233445566778899aabbccddeeff,
               1'b0, 1'b0, 1'b0, 128'h69c4e0d86a7b0430d8cdb78070b4c55a, "R3 encrypt vector A", got);
    full_check(128'h000102030405060708090a0b0c0d0e0f, 128'h69c4e0d86a7b0430d8cdb78070b4c55a,
               1'b1, 1'b0, 1'b0, 128'h00112233445566778899aabbccddeeff, "R4 decrypt vector A", got);
    full_check(128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h3243f6a8885a308d313198a2e0370734,
               1'b0, 1'b1, 1'b1, 128'h3925841d02dc09fbdc118597196a0b32, "R3 encrypt vector B stalled", got);
    full_check(128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h3925841d02dc09fbdc118597196a0b32,
               1'b1, 1'b1, 1'b1, 128'h3243f6a8885a308d313198a2e0370734, "R4 decrypt vector B stalled", got);

    // corner blocks: all zero and all ones
    full_check(128'h0, 128'h0, 1'b0, 1'b0, 1'b0, (expand_and_enc(128'h0, 128'h0)),
               "R3 zero key zero block", got);
    full_check({128{1'b1}}, {128{1'b1}}, 1'b1, 1'b0, 1'b1,
               (expand_and_dec({128{1'b1}}, {128{1'b1}})), "R4 all-ones decrypt", got);

    // R9 random round trips
    for (int i = 0; i < 14; i++) begin
      k = rnd128(); p = rnd128();
      expand(k);
      c = m_enc(p);
      full_check(k, p, 1'b0, i[0], (i % 3) == 0, c, "R9 random encrypt", got);
      full_check(k, got, 1'b1, !i[0], (i % 4) == 1, p, "R9 round trip decrypt", got);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  function automatic logic [127:0] expand_and_enc(logic [127:0] key, logic [127:0] pt);
    logic [127:0] saved [11];
    logic [127:0] r;
    saved = rk;
    expand_fn(key);
    r = m_enc(pt);
    rk = saved;
    return r;
  endfunction

  function automatic logic [127:0] expand_and_dec(logic [127:0] key, logic [127:0] ct);
    logic [127:0] saved [11];
    logic [127:0] r;
    saved = rk;
    expand_fn(key);
    r = m_dec(ct);
    rk = saved;
    return r;
  endfunction

  function automatic void expand_fn(logic [127:0] key);
    logic [31:0] w [44];
    logic [31:0] t;
    logic [7:0] rc = 8'h01;
    for (int i = 0; i < 4; i++) w[i] = key[127-32*i -: 32];
    for (int i = 4; i < 44; i++) begin
      t = w[i-1];
      if (i % 4 == 0) begin
        t = {t[23:0], t[31:24]};
        t = {sb[t[31:24]], sb[t[23:16]], sb[t[15:8]], sb[t[7:0]]} ^ {rc, 24'h0};
        rc = gm(rc, 8'h02);
      end
      w[i] = w[i-4] ^ t;
    end
    for (int r = 0; r < 11; r++) rk[r] = {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]};
  endfunction
endmodule